// File: doc/BRIEF.md
# Control Endpoint Command and Status Register

This block is the processor-facing command and status byte of a control endpoint (endpoint zero), for either end of the link. The processor writes a command byte. The block turns that byte into one transaction request toward a packet engine. The request carries the transaction kind and the data PID to use. The engine reports back with an outcome code, and the block turns the outcome into status flags that the processor reads as a byte. The same command bits mean different things in host role and in peripheral role, and the `host_mode` pin selects the role.

The block keeps the DATA0/DATA1 toggle, so the processor never handles PIDs. It keeps the received, busy, stall and error flags, and a received-byte count. A completion flag drives the interrupt line. When the engine answers NAK, the request stays raised and unchanged, so the transaction repeats until it succeeds, stalls or fails. In peripheral role, a SETUP arriving from the host resets the endpoint's transfer state at any time.

Top module: `ucp_ctrl_csr`

## Requirements
- R1: After reset, `stat_data` reads 00h, `eng_req`, `eng_stall` and `cpl_irq` are 0, `rx_bytes` is 0, and the toggle is DATA0.
- R2: Status bit positions are 0 = packet received, 1 = transaction pending (equal to `eng_req`), 2 = STALL seen or peripheral stall active, and 4 = low-level error. Bits 3, 5, 6 and 7 always read 0.
- R3: In host role, command bits 1 and 3 together (0Ah) request kind 0 (send SETUP) with PID DATA0. After success the toggle is DATA1.
- R4: In host role, command bit 1 without bits 3 and 6 requests kind 1 (send data) with the current toggle. Every success (result 0 = ACK or 1 = DATA) sets the toggle to the inverse of the PID just used.
- R5: In host role, bit 5 without bits 1 and 6 (20h) requests kind 2 (receive data). Result 2 (NAK) keeps the request, kind and PID unchanged. Result 1 (DATA) sets status bit 0 and loads `rx_bytes` from `eng_len`.
- R6: Command bit 6 sets the toggle to DATA1 before any transaction launches. In host role, 42h requests kind 3 (send status) with DATA1 and 60h requests kind 4 (receive status) with DATA1. Writing 40h alone raises no request.
- R7: Result 3 (STALL) ends the transaction, sets status bit 2 and leaves the toggle unchanged.
- R8: Result 4 (error), and any undefined result code, ends the transaction, sets status bit 4 and leaves the toggle unchanged.
- R9: `cpl_irq` is set by every ended transaction and by every received SETUP. It holds until `cpl_clr` is pulsed, and a set in the same cycle as `cpl_clr` wins.
- R10: In peripheral role, bit 1 requests kind 1. If bit 3 is also set (0Ah), success is followed automatically by a kind 4 request with DATA1. Status bit 1 stays high through both parts, and completion waits for the status part.
- R11: In peripheral role, bit 3 without bits 1 and 5 (48h) requests kind 3 (send status) with the current toggle, which is DATA1 when bit 6 is set.
- R12: In peripheral role, bit 5 (60h) raises no request. It sets `eng_stall` and status bit 2, which stay until the next accepted command or a received SETUP.
- R13: A `setup_in` pulse cancels any pending transaction. It sets status bit 0, loads `rx_bytes` with 8, sets the toggle to DATA1, clears the flags and the peripheral stall, and sets `cpl_irq`. It takes priority over a simultaneous write or engine outcome.
- R14: A write accepted while no transaction is pending clears status bits 0, 2 and 4. Writes made while a transaction is pending are ignored, and command bits 0, 2, 4 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = peripheral role |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| stat_data | output | 8 | Status byte |
| cpl_irq | output | 1 | Completion flag / interrupt line |
| cpl_clr | input | 1 | Clears the completion flag |
| rx_bytes | output | $clog2(MAX_PKT+1) | Byte count of the last received packet |
| eng_req | output | 1 | Transaction request to the packet engine |
| eng_kind | output | 3 | Transaction kind (0..4) |
| eng_pid | output | 1 | Data PID: 0 = DATA0, 1 = DATA1 |
| eng_stall | output | 1 | Peripheral stall: answer tokens with STALL |
| eng_done | input | 1 | Engine outcome strobe |
| eng_result | input | 3 | Outcome code (0 ACK, 1 DATA, 2 NAK, 3 STALL, 4 error) |
| eng_len | input | $clog2(MAX_PKT+1) | Length of a received packet |
| setup_in | input | 1 | A SETUP packet arrived from the host |

## Verification
The bench builds the block with its defaults: a 64-byte maximum packet and both roles present, so that `host_mode` switches between the two decoders at run time. With both roles present, a sweep of all 256 command bytes in each role is possible. Each sweep step completes its transaction, so the toggle value the bench predicts carries into the next command. This reaches every command bit combination, including the undefined bits, with both toggle states. Directed sequences then cover NAK repetition, the stall and error outcomes, the chained peripheral status stage, SETUP cancellation, and the set-wins rule of the completion flag.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

   // transaction kinds seen by the packet engine
   typedef enum logic [2:0] {
      K_TX_SETUP  = 3'd0,
      K_TX_DATA   = 3'd1,
      K_RX_DATA   = 3'd2,
      K_TX_STATUS = 3'd3,
      K_RX_STATUS = 3'd4
   } xfer_kind_e;

   // outcome codes reported by the packet engine
   localparam logic [2:0] RES_ACK   = 3'd0;
   localparam logic [2:0] RES_DATA  = 3'd1;
   localparam logic [2:0] RES_NAK   = 3'd2;
   localparam logic [2:0] RES_STALL = 3'd3;
   localparam logic [2:0] RES_ERR   = 3'd4;

   // command bit positions
   localparam int B_SEND = 1;
   localparam int B_AUX  = 3;
   localparam int B_REQ  = 5;
   localparam int B_TOG  = 6;

   // status bit positions
   localparam int ST_RX    = 0;
   localparam int ST_BUSY  = 1;
   localparam int ST_STALL = 2;
   localparam int ST_ERR   = 4;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_XFER = 2'd1,
      PH_STAT = 2'd2
   } phase_e;

   typedef struct packed {
      logic       launch;
      xfer_kind_e kind;
      logic       tog_rst;
      logic       chain;
      logic       stall_set;
   } cmd_dec_t;

endpackage

// File: rtl/ucp_cmd_decode.sv
module ucp_cmd_decode
   import ucp_pkg::*;
#(
   parameter bit HOST_EN = 1'b1,
   parameter bit DEV_EN  = 1'b1
) (
   input  logic       host_mode,
   input  logic [7:0] cmd,
   output cmd_dec_t   dec
);

   logic unused_bits;
   assign unused_bits = ^{cmd[7], cmd[4], cmd[2], cmd[0]};

   function automatic cmd_dec_t dec_host(input logic [7:0] c);
      cmd_dec_t d;
      d         = '0;
      d.kind    = K_TX_DATA;
      d.tog_rst = c[B_TOG];
      if (c[B_SEND]) begin
         d.launch = 1'b1;
         if (c[B_AUX])
            d.kind = K_TX_SETUP;
         else
            d.kind = c[B_TOG] ? K_TX_STATUS : K_TX_DATA;
      end else if (c[B_REQ]) begin
         d.launch = 1'b1;
         d.kind   = c[B_TOG] ? K_RX_STATUS : K_RX_DATA;
      end
      return d;
   endfunction

   function automatic cmd_dec_t dec_dev(input logic [7:0] c);
      cmd_dec_t d;
      d         = '0;
      d.kind    = K_TX_DATA;
      d.tog_rst = c[B_TOG];
      if (c[B_REQ]) begin
         d.stall_set = 1'b1;
      end else if (c[B_SEND]) begin
         d.launch = 1'b1;
         d.kind   = K_TX_DATA;
         d.chain  = c[B_AUX];
      end else if (c[B_AUX]) begin
         d.launch = 1'b1;
         d.kind   = K_TX_STATUS;
      end
      return d;
   endfunction

   generate
      if (HOST_EN && DEV_EN) begin : g_both
         always_comb dec = host_mode ? dec_host(cmd) : dec_dev(cmd);
      end else if (HOST_EN) begin : g_host
         logic unused_mode;
         assign unused_mode = host_mode;
         always_comb dec = dec_host(cmd);
      end else begin : g_dev
         logic unused_mode;
         assign unused_mode = host_mode;
         always_comb dec = dec_dev(cmd);
      end
   endgenerate

endmodule

// File: rtl/ucp_seq.sv
module ucp_seq
   import ucp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc,
   input  cmd_dec_t   dec,
   input  logic       setup_in,
   input  logic       done,
   input  logic [2:0] result,
   output logic       busy,
   output xfer_kind_e kind,
   output logic       pid,
   output logic       ev_fin,
   output logic       ev_rx,
   output logic       ev_stall,
   output logic       ev_err
);

   phase_e     phase_q;
   xfer_kind_e kind_q;
   logic       chain_q;
   logic       tog_q;

   logic live;
   logic ok;
   logic to_stat;

   assign busy    = (phase_q != PH_IDLE);
   assign kind    = kind_q;
   assign pid     = (kind_q == K_TX_SETUP) ? 1'b0 : tog_q;
   assign live    = busy && done && !setup_in;
   assign ok      = (result == RES_ACK) || (result == RES_DATA);
   assign to_stat = chain_q && (phase_q == PH_XFER);

   assign ev_fin   = live && (result != RES_NAK) && !(ok && to_stat);
   assign ev_rx    = live && (result == RES_DATA);
   assign ev_stall = live && (result == RES_STALL);
   assign ev_err   = live && !ok && (result != RES_NAK) && (result != RES_STALL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= K_TX_DATA;
         chain_q <= 1'b0;
         tog_q   <= 1'b0;
      end else if (setup_in) begin
         phase_q <= PH_IDLE;
         chain_q <= 1'b0;
         tog_q   <= 1'b1;
      end else if (acc) begin
         if (dec.tog_rst)
            tog_q <= 1'b1;
         if (dec.launch) begin
            phase_q <= PH_XFER;
            kind_q  <= dec.kind;
            chain_q <= dec.chain;
         end
      end else if (live) begin
         if (ok) begin
            if (to_stat) begin
               phase_q <= PH_STAT;
               kind_q  <= K_RX_STATUS;
               tog_q   <= 1'b1;
            end else begin
               phase_q <= PH_IDLE;
               tog_q   <= ~pid;
            end
         end else if (result != RES_NAK) begin
            phase_q <= PH_IDLE;
         end
      end
   end

endmodule

// File: rtl/ucp_flags.sv
module ucp_flags
   import ucp_pkg::*;
#(
   parameter int CNT_W     = 7,
   parameter int SETUP_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_in,
   input  logic             acc,
   input  logic             stall_set,
   input  logic             busy,
   input  logic             ev_fin,
   input  logic             ev_rx,
   input  logic             ev_stall,
   input  logic             ev_err,
   input  logic [CNT_W-1:0] rx_len,
   input  logic             cpl_clr,
   output logic [7:0]       stat,
   output logic             stall_mode,
   output logic             cpl,
   output logic [CNT_W-1:0] rx_bytes
);

   logic             rx_q;
   logic             stall_q;
   logic             err_q;
   logic             smode_q;
   logic             cpl_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q    <= 1'b0;
         stall_q <= 1'b0;
         err_q   <= 1'b0;
         smode_q <= 1'b0;
         cnt_q   <= '0;
      end else if (setup_in) begin
         rx_q    <= 1'b1;
         stall_q <= 1'b0;
         err_q   <= 1'b0;
         smode_q <= 1'b0;
         cnt_q   <= CNT_W'(SETUP_LEN);
      end else if (acc) begin
         rx_q    <= 1'b0;
         stall_q <= 1'b0;
         err_q   <= 1'b0;
         smode_q <= stall_set;
      end else begin
         if (ev_rx) begin
            rx_q  <= 1'b1;
            cnt_q <= rx_len;
         end
         if (ev_stall)
            stall_q <= 1'b1;
         if (ev_err)
            err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cpl_q <= 1'b0;
      else if (setup_in || ev_fin)
         cpl_q <= 1'b1;
      else if (cpl_clr)
         cpl_q <= 1'b0;
   end

   generate
      for (genvar i = 0; i < 8; i++) begin : g_bit
         if (i == ST_RX) begin : g_rx
            assign stat[i] = rx_q;
         end else if (i == ST_BUSY) begin : g_busy
            assign stat[i] = busy;
         end else if (i == ST_STALL) begin : g_stall
            assign stat[i] = stall_q | smode_q;
         end else if (i == ST_ERR) begin : g_err
            assign stat[i] = err_q;
         end else begin : g_zero
            assign stat[i] = 1'b0;
         end
      end
   endgenerate

   assign stall_mode = smode_q;
   assign cpl        = cpl_q;
   assign rx_bytes   = cnt_q;

endmodule

// File: rtl/ucp_ctrl_csr.sv
module ucp_ctrl_csr
   import ucp_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter bit HOST_EN = 1'b1,
   parameter bit DEV_EN  = 1'b1,
   localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mode,
   input  logic             cmd_wr,
   input  logic [7:0]       cmd_data,
   output logic [7:0]       stat_data,
   output logic             cpl_irq,
   input  logic             cpl_clr,
   output logic [CNT_W-1:0] rx_bytes,
   output logic             eng_req,
   output logic [2:0]       eng_kind,
   output logic             eng_pid,
   output logic             eng_stall,
   input  logic             eng_done,
   input  logic [2:0]       eng_result,
   input  logic [CNT_W-1:0] eng_len,
   input  logic             setup_in
);

   localparam int SETUP_LEN = 8;

   generate
      if (!(HOST_EN || DEV_EN)) begin : g_bad_role
         $error("ucp_ctrl_csr: at least one role must be enabled");
      end
      if (MAX_PKT < SETUP_LEN) begin : g_bad_pkt
         $error("ucp_ctrl_csr: MAX_PKT must hold a SETUP packet");
      end
   endgenerate

   cmd_dec_t   dec;
   logic       busy;
   logic       acc;
   xfer_kind_e kind;
   logic       ev_fin, ev_rx, ev_stall, ev_err;

   assign acc = cmd_wr && !busy && !setup_in;

   ucp_cmd_decode #(
      .HOST_EN (HOST_EN),
      .DEV_EN  (DEV_EN)
   ) u_dec (
      .host_mode (host_mode),
      .cmd       (cmd_data),
      .dec       (dec)
   );

   ucp_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .dec      (dec),
      .setup_in (setup_in),
      .done     (eng_done),
      .result   (eng_result),
      .busy     (busy),
      .kind     (kind),
      .pid      (eng_pid),
      .ev_fin   (ev_fin),
      .ev_rx    (ev_rx),
      .ev_stall (ev_stall),
      .ev_err   (ev_err)
   );

   ucp_flags #(
      .CNT_W     (CNT_W),
      .SETUP_LEN (SETUP_LEN)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_in   (setup_in),
      .acc        (acc),
      .stall_set  (dec.stall_set),
      .busy       (busy),
      .ev_fin     (ev_fin),
      .ev_rx      (ev_rx),
      .ev_stall   (ev_stall),
      .ev_err     (ev_err),
      .rx_len     (eng_len),
      .cpl_clr    (cpl_clr),
      .stat       (stat_data),
      .stall_mode (eng_stall),
      .cpl        (cpl_irq),
      .rx_bytes   (rx_bytes)
   );

   assign eng_req  = busy;
   assign eng_kind = kind;

endmodule

// File: rtl/ucp_ctrl_csr_chk.sv
module ucp_ctrl_csr_chk #(
   parameter int MAX_PKT = 64,
   localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_wr,
   input logic [7:0]       stat_data,
   input logic             cpl_irq,
   input logic             cpl_clr,
   input logic [CNT_W-1:0] rx_bytes,
   input logic             eng_req,
   input logic [2:0]       eng_kind,
   input logic             eng_pid,
   input logic             eng_stall,
   input logic             eng_done,
   input logic [2:0]       eng_result,
   input logic             setup_in
);

   assert_rdzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_data[3] == 1'b0) && (stat_data[7:5] == 3'b000));

   assert_setup_pid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_kind == 3'd0) |-> !eng_pid);

   assert_nak_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_done && eng_result == 3'd2 && !setup_in)
      |=> (eng_req && $stable(eng_kind) && $stable(eng_pid)));

   assert_stall_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_done && eng_result == 3'd3 && !setup_in)
      |=> (!eng_req && stat_data[2] && cpl_irq));

   assert_err_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_done && eng_result == 3'd4 && !setup_in)
      |=> (!eng_req && stat_data[4] && cpl_irq));

   assert_cpl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_irq && !cpl_clr) |=> cpl_irq);

   assert_stall_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stall |-> (!eng_req && stat_data[2]));

   assert_setup_R13: assert property (@(posedge clk) disable iff (!rst_n)
      setup_in |=> (stat_data[0] && !eng_req && !eng_stall && cpl_irq
                    && rx_bytes == CNT_W'(8)));

   assert_busy_ignore_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && cmd_wr && !eng_done && !setup_in)
      |=> (eng_req && $stable(eng_kind) && $stable(eng_pid)));

endmodule

bind ucp_ctrl_csr ucp_ctrl_csr_chk #(.MAX_PKT(MAX_PKT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_wr     (cmd_wr),
   .stat_data  (stat_data),
   .cpl_irq    (cpl_irq),
   .cpl_clr    (cpl_clr),
   .rx_bytes   (rx_bytes),
   .eng_req    (eng_req),
   .eng_kind   (eng_kind),
   .eng_pid    (eng_pid),
   .eng_stall  (eng_stall),
   .eng_done   (eng_done),
   .eng_result (eng_result),
   .setup_in   (setup_in)
);

// File: tb/ucp_ctrl_csr_test.sv
module ucp_ctrl_csr_test;

   localparam int MAX_PKT = 64;
   localparam int CNT_W   = $clog2(MAX_PKT + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             host_mode = 1'b1;
   logic             cmd_wr = 1'b0;
   logic [7:0]       cmd_data = 8'h00;
   logic [7:0]       stat_data;
   logic             cpl_irq;
   logic             cpl_clr = 1'b0;
   logic [CNT_W-1:0] rx_bytes;
   logic             eng_req;
   logic [2:0]       eng_kind;
   logic             eng_pid;
   logic             eng_stall;
   logic             eng_done = 1'b0;
   logic [2:0]       eng_result = 3'd0;
   logic [CNT_W-1:0] eng_len = '0;
   logic             setup_in = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit tog = 1'b0;

   always #2 clk = ~clk;

   ucp_ctrl_csr #(.MAX_PKT(MAX_PKT)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_mode  (host_mode),
      .cmd_wr     (cmd_wr),
      .cmd_data   (cmd_data),
      .stat_data  (stat_data),
      .cpl_irq    (cpl_irq),
      .cpl_clr    (cpl_clr),
      .rx_bytes   (rx_bytes),
      .eng_req    (eng_req),
      .eng_kind   (eng_kind),
      .eng_pid    (eng_pid),
      .eng_stall  (eng_stall),
      .eng_done   (eng_done),
      .eng_result (eng_result),
      .eng_len    (eng_len),
      .setup_in   (setup_in)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk);
      cmd_wr   = 1'b1;
      cmd_data = b;
      @(negedge clk);
      cmd_wr   = 1'b0;
      cmd_data = 8'h00;
   endtask

   task automatic fin(input logic [2:0] res, input int len);
      @(negedge clk);
      eng_done   = 1'b1;
      eng_result = res;
      eng_len    = CNT_W'(len);
      @(negedge clk);
      eng_done   = 1'b0;
   endtask

   task automatic clr_irq();
      @(negedge clk);
      cpl_clr = 1'b1;
      @(negedge clk);
      cpl_clr = 1'b0;
   endtask

   task automatic setup_pulse();
      @(negedge clk);
      setup_in = 1'b1;
      @(negedge clk);
      setup_in = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 stat", stat_data, 8'h00);
      check("R1 req", eng_req, 0);
      check("R1 irq", cpl_irq, 0);
      check("R1 stall", eng_stall, 0);
      check("R1 rx_bytes", rx_bytes, 0);

      // sweep every command byte in both roles, tracking the toggle
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            bit tn, launch, chain, stl;
            logic [2:0] k;
            bit p;
            cb = c[7:0];
            host_mode = (m == 0);
            tn = cb[6] ? 1'b1 : tog;
            launch = 0; chain = 0; stl = 0; k = 3'd0; p = tn;
            if (m == 0) begin
               if (cb[1]) begin
                  launch = 1;
                  if (cb[3]) begin k = 3'd0; p = 1'b0; end
                  else k = cb[6] ? 3'd3 : 3'd1;
               end else if (cb[5]) begin
                  launch = 1;
                  k = cb[6] ? 3'd4 : 3'd2;
               end
            end else begin
               if (cb[5]) stl = 1;
               else if (cb[1]) begin launch = 1; k = 3'd1; chain = cb[3]; end
               else if (cb[3]) begin launch = 1; k = 3'd3; end
            end
            wr(cb);
            check($sformatf("R2 R14 sweep stat cmd %02h", cb), stat_data,
                  {5'b0, stl, launch, 1'b0});
            check($sformatf("R14 sweep req cmd %02h", cb), eng_req, launch);
            check($sformatf("R12 sweep stall cmd %02h", cb), eng_stall, stl);
            if (launch) begin
               check($sformatf("R4 sweep kind cmd %02h", cb), eng_kind, k);
               check($sformatf("R6 sweep pid cmd %02h", cb), eng_pid, p);
               fin(3'd0, 0);
               if (chain) begin
                  check("R10 sweep chained kind", eng_kind, 3'd4);
                  check("R10 sweep chained pid", eng_pid, 1);
                  check("R10 sweep chained busy", stat_data[1], 1);
                  check("R10 sweep irq waits", cpl_irq, 0);
                  fin(3'd0, 0);
                  tog = 1'b0;
               end else begin
                  tog = ~p;
               end
               check("R9 sweep end req", eng_req, 0);
               check("R9 sweep irq", cpl_irq, 1);
               clr_irq();
            end else begin
               tog = tn;
            end
         end
      end

      // host role directed cases
      host_mode = 1'b1;
      wr(8'h40);                       // toggle -> DATA1
      check("R6 40h no request", eng_req, 0);
      wr(8'h02); check("R6 pid after 40h", eng_pid, 1); fin(3'd0, 0);   // tog 0
      wr(8'h0A);
      check("R3 setup kind", eng_kind, 0);
      check("R3 setup pid", eng_pid, 0);
      fin(3'd0, 0);
      wr(8'h02);
      check("R3 toggle DATA1 after setup", eng_pid, 1);
      check("R4 kind", eng_kind, 1);
      fin(3'd0, 0);
      wr(8'h02);
      check("R4 toggle flipped", eng_pid, 0);
      fin(3'd0, 0);                    // tog 1
      clr_irq();

      wr(8'h20);
      check("R5 kind", eng_kind, 2);
      check("R5 pid", eng_pid, 1);
      fin(3'd2, 0);
      check("R5 NAK keeps req", eng_req, 1);
      check("R5 NAK keeps pid", eng_pid, 1);
      check("R5 NAK no irq", cpl_irq, 0);
      fin(3'd2, 0);
      check("R5 second NAK kind", eng_kind, 2);
      fin(3'd1, 13);
      check("R5 rx stat", stat_data, 8'h01);
      check("R5 rx_bytes", rx_bytes, 13);
      check("R9 irq after data", cpl_irq, 1);
      clr_irq();
      wr(8'h02);
      check("R5 toggle flipped after DATA", eng_pid, 0);
      fin(3'd0, 0);                    // tog 1

      wr(8'h42);
      check("R6 42h kind", eng_kind, 3);
      check("R6 42h pid", eng_pid, 1);
      fin(3'd0, 0);                    // tog 0
      wr(8'h60);
      check("R6 60h kind", eng_kind, 4);
      check("R6 60h pid", eng_pid, 1);
      fin(3'd1, 0);                    // tog 0
      check("R6 status rx_bytes", rx_bytes, 0);
      clr_irq();

      wr(8'h02);
      fin(3'd3, 0);
      check("R7 stall stat", stat_data, 8'h04);
      check("R7 irq", cpl_irq, 1);
      wr(8'h02);
      check("R7 toggle unchanged", eng_pid, 0);
      check("R14 new command clears stall", stat_data, 8'h02);
      fin(3'd4, 0);
      check("R8 error stat", stat_data, 8'h10);
      wr(8'h02);
      check("R8 toggle unchanged", eng_pid, 0);
      fin(3'd7, 0);
      check("R8 undefined result is error", stat_data, 8'h10);
      wr(8'h00);
      check("R14 00h clears flags", stat_data, 8'h00);
      check("R14 00h no request", eng_req, 0);

      // completion hold and set-wins
      repeat (3) @(negedge clk);
      check("R9 irq holds", cpl_irq, 1);
      clr_irq();
      check("R9 irq cleared", cpl_irq, 0);
      wr(8'h02);                       // pid 0
      @(negedge clk);
      cpl_clr = 1'b1; eng_done = 1'b1; eng_result = 3'd0;
      @(negedge clk);
      cpl_clr = 1'b0; eng_done = 1'b0;
      check("R9 set wins over clear", cpl_irq, 1);
      clr_irq();                       // tog 1

      // writes while busy are ignored
      wr(8'h02);
      wr(8'h20);
      check("R14 busy write ignored kind", eng_kind, 1);
      check("R14 busy write ignored pid", eng_pid, 1);
      fin(3'd0, 0);                    // tog 0
      clr_irq();

      // peripheral role
      host_mode = 1'b0;
      wr(8'h02);
      setup_pulse();
      check("R13 cancels request", eng_req, 0);
      check("R13 stat", stat_data, 8'h01);
      check("R13 rx_bytes", rx_bytes, 8);
      check("R13 irq", cpl_irq, 1);
      clr_irq();
      wr(8'h02);
      check("R13 toggle DATA1", eng_pid, 1);
      fin(3'd0, 0);                    // tog 0
      clr_irq();

      wr(8'h60);
      check("R12 stall out", eng_stall, 1);
      check("R12 stat", stat_data, 8'h04);
      check("R12 no request", eng_req, 0);
      setup_pulse();
      check("R13 clears stall", eng_stall, 0);
      clr_irq();
      wr(8'h20);
      check("R12 20h stalls", eng_stall, 1);
      wr(8'h00);
      check("R12 next command clears", eng_stall, 0);

      wr(8'h40);
      wr(8'h0A);
      check("R10 data kind", eng_kind, 1);
      check("R10 data pid", eng_pid, 1);
      fin(3'd0, 0);
      check("R10 status kind", eng_kind, 4);
      check("R10 status pid", eng_pid, 1);
      check("R10 busy held", stat_data[1], 1);
      check("R10 no irq yet", cpl_irq, 0);
      fin(3'd1, 0);
      check("R10 done req", eng_req, 0);
      check("R10 irq", cpl_irq, 1);
      clr_irq();

      wr(8'h48);
      check("R11 kind", eng_kind, 3);
      check("R11 pid", eng_pid, 1);
      fin(3'd0, 0);
      check("R11 end", eng_req, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule